// File: doc/BRIEF.md
# Packed Logical Right Shifter

This block shifts a 64-bit packed operand right, lane by lane, filling the vacated upper bits of each lane with zeros. The lane width comes from the opcode. Words give four 16-bit lanes, doublewords give two 32-bit lanes, and a quadword gives one 64-bit lane. All lanes move by the same unsigned count. No bit crosses from one lane into the next.

The count has two possible sources: a 64-bit count operand or an 8-bit immediate. A small decoder reads an escape byte, an operation byte and the 3-bit reg field of the ModRM byte. From these it picks the lane width and the count source. Any count at or above the lane width clears the whole result. The range test covers all 64 count bits, so a large count never wraps to a small one. The block has one register stage. Each cycle it registers the result together with a flag saying whether the opcode was recognised.

Top module: `packed_srl`

## Requirements
- R1: With escape byte 0x0F and operation byte 0xD1, each 16-bit lane is shifted right independently, with zero fill. For example, lanes 0xFFFC and 0x11C7 shifted by 2 give 0x3FFF and 0x0471.
- R2: With operation byte 0xD2, each of the two 32-bit lanes is shifted right independently, with zero fill.
- R3: With operation byte 0xD3, the whole 64-bit operand is shifted right as one lane, with zero fill.
- R4: If the unsigned 64-bit count is greater than 15 (word), 31 (doubleword) or 63 (quadword), the whole result is zero. Set high count bits, such as 0x1_0000_0001, also clear the result.
- R5: In the immediate forms, the 8-bit immediate is zero-extended before the range test. An immediate of 0x80 clears the result in every lane width.
- R6: Operation bytes 0xD1, 0xD2 and 0xD3 take the 64-bit count operand and ignore the immediate and the reg field.
- R7: Operation bytes 0x71, 0x72 and 0x73 take the immediate as the count and select word, doubleword and quadword lanes. These forms are recognised only when the reg field equals 2.
- R8: Any other escape or operation byte, and any immediate form whose reg field is not 2, give a flag of 0 and a result of 0.
- R9: A count of zero returns the data operand unchanged.
- R10: The result and the flag appear one clock edge after the inputs. While reset is held, both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| esc_byte | input | 8 | First opcode byte; 0x0F for every recognised form |
| op_byte | input | 8 | Second opcode byte; selects lane width and count source |
| reg_fld | input | 3 | ModRM reg field; must be 2 for immediate forms |
| data_in | input | 64 | Packed operand to shift |
| cnt_in | input | 64 | Unsigned 64-bit count operand |
| imm_in | input | 8 | Immediate count |
| res_out | output | 64 | Registered shifted result |
| res_ok | output | 1 | Registered flag: opcode was recognised |

## Verification
The checker compares each output with the decoded inputs of the previous cycle. It therefore assumes that the inputs hold defined values at every edge from the first edge after reset, including cycles where the opcode is not recognised. The bench follows this assumption. It drives every input from time zero and changes inputs only between clock edges. Every count is chosen explicitly: the sweeps cover all counts up to 70, each single high bit, and all-ones, so the range assertions always see a known 64-bit value.

// File: rtl/psr_pkg.sv
package psr_pkg;
    localparam int WORD_W = 64;
    localparam int IMM_W  = 8;

    typedef enum logic [1:0] {
        LM_NONE = 2'd0,
        LM_16   = 2'd1,
        LM_32   = 2'd2,
        LM_64   = 2'd3
    } lane_mode_e;

    typedef struct packed {
        logic       ok;
        lane_mode_e mode;
        logic       use_imm;
    } dec_t;
endpackage

// File: rtl/psr_decode.sv
module psr_decode
    import psr_pkg::*;
#(
    parameter logic [7:0] ESC     = 8'h0F,
    parameter logic [3:0] REG_HI  = 4'hD,
    parameter logic [3:0] IMM_HI  = 4'h7,
    parameter logic [2:0] IMM_REG = 3'd2
) (
    input  logic [7:0] esc_byte,
    input  logic [7:0] op_byte,
    input  logic [2:0] reg_fld,
    output dec_t       dec
);
    logic esc_hit, low_hit, reg_form, imm_form;

    always_comb begin
        esc_hit  = (esc_byte == ESC);
        // low nibble must be 1..3: the two low bits name the lane width
        low_hit  = (op_byte[3:2] == 2'b00) && (op_byte[1:0] != 2'b00);
        reg_form = esc_hit && low_hit && (op_byte[7:4] == REG_HI);
        imm_form = esc_hit && low_hit && (op_byte[7:4] == IMM_HI)
                   && (reg_fld == IMM_REG);
        dec         = '0;
        dec.ok      = reg_form || imm_form;
        dec.use_imm = imm_form;
        dec.mode    = dec.ok ? lane_mode_e'(op_byte[1:0]) : LM_NONE;
    end
endmodule

// File: rtl/psr_lane_shift.sv
module psr_lane_shift #(
    parameter int DATA_W = 64,
    parameter int LANE_W = 16
) (
    input  logic [DATA_W-1:0] data,
    input  logic [DATA_W-1:0] cnt,
    output logic [DATA_W-1:0] res
);
    localparam int N_LANES = DATA_W / LANE_W;
    localparam int SH_W    = $clog2(LANE_W);

    logic over;
    // any bit at or above the lane-width exponent makes the count too large
    assign over = |cnt[DATA_W-1:SH_W];

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        assign res[g*LANE_W +: LANE_W] =
            over ? '0 : (data[g*LANE_W +: LANE_W] >> cnt[SH_W-1:0]);
    end
endmodule

// File: rtl/packed_srl.sv
module packed_srl
    import psr_pkg::*;
#(
    parameter int DATA_W = psr_pkg::WORD_W,
    parameter int IMM_W  = psr_pkg::IMM_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        esc_byte,
    input  logic [7:0]        op_byte,
    input  logic [2:0]        reg_fld,
    input  logic [DATA_W-1:0] data_in,
    input  logic [DATA_W-1:0] cnt_in,
    input  logic [IMM_W-1:0]  imm_in,
    output logic [DATA_W-1:0] res_out,
    output logic              res_ok
);
    localparam int N_MODES = 3;

    typedef struct packed {
        logic              ok;
        logic [DATA_W-1:0] res;
    } st_t;

    dec_t              dec;
    logic [DATA_W-1:0] cnt_eff;
    logic [DATA_W-1:0] cand [N_MODES];
    st_t               st_d, st_q;

    psr_decode u_dec (
        .esc_byte (esc_byte),
        .op_byte  (op_byte),
        .reg_fld  (reg_fld),
        .dec      (dec)
    );

    assign cnt_eff = dec.use_imm ? {{(DATA_W-IMM_W){1'b0}}, imm_in} : cnt_in;

    // index 0: quarter-width lanes, 1: half-width, 2: full width
    for (genvar m = 0; m < N_MODES; m++) begin : g_mode
        psr_lane_shift #(
            .DATA_W (DATA_W),
            .LANE_W (DATA_W >> (N_MODES - 1 - m))
        ) u_sh (
            .data (data_in),
            .cnt  (cnt_eff),
            .res  (cand[m])
        );
    end

    always_comb begin
        st_d    = '0;
        st_d.ok = dec.ok;
        unique case (dec.mode)
            LM_16:   st_d.res = cand[0];
            LM_32:   st_d.res = cand[1];
            LM_64:   st_d.res = cand[2];
            default: st_d.res = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_out = st_q.res;
    assign res_ok  = st_q.ok;
endmodule

// File: rtl/psr_chk.sv
module psr_chk #(
    parameter int DATA_W = 64,
    parameter int IMM_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [7:0]        esc_byte,
    input logic [7:0]        op_byte,
    input logic [2:0]        reg_fld,
    input logic [DATA_W-1:0] data_in,
    input logic [DATA_W-1:0] cnt_in,
    input logic [IMM_W-1:0]  imm_in,
    input logic [DATA_W-1:0] res_out,
    input logic              res_ok
);
    logic armed_q;
    logic reg_form, imm_bad, hi_cnt, dw_form;

    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    assign reg_form = (esc_byte == 8'h0F) && (op_byte inside {8'hD1, 8'hD2, 8'hD3});
    assign dw_form  = (esc_byte == 8'h0F) && (op_byte == 8'hD2);
    assign imm_bad  = (esc_byte == 8'h0F) && (op_byte inside {8'h71, 8'h72, 8'h73})
                      && (reg_fld != 3'd2);
    assign hi_cnt   = |cnt_in[DATA_W-1:6];

    a_r8_invalid_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !res_ok |-> (res_out == '0));

    a_r6_reg_form_ok: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(dw_form)) |-> res_ok);

    a_r7_imm_reg_field: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(imm_bad)) |-> !res_ok);

    a_r4_high_count: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(reg_form && hi_cnt)) |-> (res_out == '0));

    a_r9_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(reg_form && (cnt_in == '0))) |-> (res_out == $past(data_in)));
endmodule

bind packed_srl psr_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .esc_byte (esc_byte),
    .op_byte  (op_byte),
    .reg_fld  (reg_fld),
    .data_in  (data_in),
    .cnt_in   (cnt_in),
    .imm_in   (imm_in),
    .res_out  (res_out),
    .res_ok   (res_ok)
);

// File: tb/tb_packed_srl.sv
module tb_packed_srl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  esc_byte = 8'h00;
    logic [7:0]  op_byte = 8'h00;
    logic [2:0]  reg_fld = 3'd0;
    logic [63:0] data_in = '0;
    logic [63:0] cnt_in = '0;
    logic [7:0]  imm_in = '0;
    logic [63:0] res_out;
    logic        res_ok;

    int n_vec = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    packed_srl dut (
        .clk(clk), .rst_n(rst_n), .esc_byte(esc_byte), .op_byte(op_byte),
        .reg_fld(reg_fld), .data_in(data_in), .cnt_in(cnt_in), .imm_in(imm_in),
        .res_out(res_out), .res_ok(res_ok)
    );

    function automatic logic [64:0] model(input logic [7:0] e, input logic [7:0] o,
                                          input logic [2:0] r, input logic [63:0] d,
                                          input logic [63:0] c, input logic [7:0] im);
        int w = 0;
        logic use_imm = 1'b0;
        logic [63:0] cc;
        logic [63:0] res = '0;
        if (e == 8'h0F) begin
            if (o == 8'hD1) w = 16;
            if (o == 8'hD2) w = 32;
            if (o == 8'hD3) w = 64;
            if (r == 3'd2) begin
                if (o == 8'h71) begin w = 16; use_imm = 1'b1; end
                if (o == 8'h72) begin w = 32; use_imm = 1'b1; end
                if (o == 8'h73) begin w = 64; use_imm = 1'b1; end
            end
        end
        if (w == 0) return 65'd0;
        cc = use_imm ? {56'd0, im} : c;
        if (cc < 64'(w)) begin
            for (int l = 0; l < 64 / w; l++)
                for (int b = 0; b < w; b++)
                    if (b + int'(cc) < w) res[l*w + b] = d[l*w + b + int'(cc)];
        end
        return {1'b1, res};
    endfunction

    task automatic apply(input string tag, input logic [7:0] e, input logic [7:0] o,
                         input logic [2:0] r, input logic [63:0] d,
                         input logic [63:0] c, input logic [7:0] im);
        logic [64:0] exp;
        esc_byte = e; op_byte = o; reg_fld = r; data_in = d; cnt_in = c; imm_in = im;
        exp = model(e, o, r, d, c, im);
        @(posedge clk);
        #1;
        n_vec++;
        if (res_ok !== exp[64] || res_out !== exp[63:0]) begin
            n_bad++;
            $display("FAIL %s: got ok=%0b res=%h expected ok=%0b res=%h",
                     tag, res_ok, res_out, exp[64], exp[63:0]);
        end
    endtask

    function automatic string tag_for(input int w, input logic [63:0] c);
        if (c == 0) return "R9";
        if (c >= 64'(w)) return "R4";
        return (w == 16) ? "R1" : (w == 32) ? "R2" : "R3";
    endfunction

    initial begin : watchdog
        #(200000 * 4);
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : main
        logic [63:0] pats [4];
        logic [63:0] cnts [131];
        int nc = 0;
        pats[0] = 64'hFFFC_11C7_FFFC_11C7;
        pats[1] = 64'hFFFF_FFFF_FFFF_FFFF;
        pats[2] = {$urandom, $urandom};
        pats[3] = 64'h8000_0001_8000_8001;
        for (int i = 0; i <= 70; i++) begin cnts[nc] = 64'(i); nc++; end
        for (int k = 6; k < 64; k++) begin cnts[nc] = 64'd1 << k; nc++; end
        cnts[nc] = 64'h1_0000_0001; nc++;
        cnts[nc] = '1; nc++;

        // R10: reset state
        repeat (3) @(posedge clk);
        #1;
        n_vec++;
        if (res_ok !== 1'b0 || res_out !== 64'd0) begin
            n_bad++;
            $display("FAIL R10: got ok=%0b res=%h expected ok=0 res=0", res_ok, res_out);
        end
        rst_n = 1'b1;

        // R1 and R7: worked example through both count sources
        apply("R1", 8'h0F, 8'hD1, 3'd5, pats[0], 64'd2, 8'hFF);
        apply("R7", 8'h0F, 8'h71, 3'd2, pats[0], 64'hFF, 8'd2);
        // R10: back-to-back inputs, each result one edge later
        apply("R10", 8'h0F, 8'hD3, 3'd0, pats[1], 64'd4, 8'd0);
        apply("R10", 8'h0F, 8'hD2, 3'd0, pats[1], 64'd8, 8'd0);

        // R1 R2 R3 R4 R9 R6: count sweep in each lane width, immediate ignored
        for (int m = 1; m <= 3; m++)
            for (int p = 0; p < 4; p++)
                for (int i = 0; i < nc; i++)
                    apply(tag_for(16 << (m - 1), cnts[i]), 8'h0F, 8'hD0 | 8'(m),
                          3'(i), pats[p], cnts[i], 8'(i * 7));

        // R5 R7: every immediate value in each width, count operand set to zero
        for (int m = 1; m <= 3; m++)
            for (int v = 0; v < 256; v++)
                apply((v >= (16 << (m - 1))) ? "R5" : "R7", 8'h0F, 8'h70 | 8'(m),
                      3'd2, pats[2] ^ 64'(v), 64'd0, 8'(v));

        // R7 R8: immediate forms with every other reg field
        for (int m = 1; m <= 3; m++)
            for (int r = 0; r < 8; r++)
                if (r != 2) apply("R7", 8'h0F, 8'h70 | 8'(m), 3'(r), pats[1], 64'd1, 8'd1);

        // R8 R6: every operation byte under the escape, then wrong escape bytes
        for (int o = 0; o < 256; o++)
            for (int r = 0; r < 8; r += 2)
                apply("R8", 8'h0F, 8'(o), 3'(r), pats[3], 64'd3, 8'd3);
        for (int e = 0; e < 256; e++)
            if (e != 8'h0F) apply("R8", 8'(e), 8'hD1, 3'd2, pats[1], 64'd1, 8'd1);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule